// File: doc/BRIEF.md
# External Interrupt Acceptance Logic

This block sits between a single-line external interrupt controller interface and the exception entry unit of a processor core. The controller presents one request at a time, made of a valid line, an interrupt level, a target register set, a nonmaskable flag and a handler address. The block compares the request against the live status register of the core and decides whether the core takes it now.

When the request is taken, the block raises a one-cycle accept pulse toward the pipeline and holds a copy of the accepted handler address, level, register set and nonmaskable flag. The entry unit works from that copy. No further request is taken until the entry unit reports that it has finished servicing the one already accepted.

A nonmaskable request looks only at whether a nonmaskable handler is already running. A maskable request must pass three tests. The interrupt enable must be set. The requested level must exceed the running level. A request for the register set already in use is taken only when re-entry into the same set is allowed.

Top module: `ext_irq_accept`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it is released, `acc_pulse` is 0 and all captured request outputs are 0 until the first accept.
- R2: A request with `req_nmi`=1 is accepted exactly when status bit 22 (nonmaskable-active) is 0. The interrupt enable, the level and the register-set fields of status have no effect on it.
- R3: A maskable request (`req_nmi`=0) is rejected when status bit 0 (interrupt enable) is 0.
- R4: A maskable request is rejected unless `req_level` is strictly greater than the current level in status bits 9:4. An equal level is rejected.
- R5: A maskable request that passes R3 and R4 and whose `req_rset` differs from the current register set in status bits 15:10 is accepted, whatever the value of status bit 23.
- R6: A maskable request that passes R3 and R4 and whose `req_rset` equals status bits 15:10 is accepted only when status bit 23 (same-set re-entry enable) is 1.
- R7: An acceptable request sampled at a clock edge makes `acc_pulse` high for exactly the following cycle. At that same edge, `acc_handler`, `acc_level`, `acc_rset` and `acc_nmi` load the request's values.
- R8: After an accept, `acc_pulse` stays low and the captured outputs hold until `svc_done` has been sampled high. The earliest new accept happens at the edge after the one that sampled `svc_done`.
- R9: With `req_valid` low, no accept occurs, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | External controller presents a request |
| req_level | input | LVL_W | Requested interrupt level |
| req_rset | input | RS_W | Requested register set |
| req_nmi | input | 1 | Request is nonmaskable |
| req_handler | input | ADDR_W | Requested handler address |
| cur_status | input | STAT_W | Live status register of the core |
| svc_done | input | 1 | Entry unit has finished with the accepted request |
| acc_pulse | output | 1 | One-cycle accept strobe |
| acc_handler | output | ADDR_W | Captured handler address |
| acc_level | output | LVL_W | Captured interrupt level |
| acc_rset | output | RS_W | Captured register set |
| acc_nmi | output | 1 | Captured nonmaskable flag |

## Verification
The vector table covers each step of the decision chain in turn. One vector sets the nonmaskable-active bit, which splits the nonmaskable override from the maskable path. Another runs a nonmaskable request with the enable off and the level maxed, which shows that those fields do not touch it. Level pairs below, equal to and one above the current level tell the strict comparison apart from a greater-or-equal one. Matching and differing register sets, each with the re-entry bit set and cleared, show that the re-entry bit gates only the same-set case. Directed sequences hold a second, acceptable request through a busy window and then release it with `svc_done`, which pins down the pulse width, the holding of the captured fields and the cycle in which the next accept may first occur.

// File: rtl/eia_pkg.sv
// eia_pkg: field positions of the core status register that the acceptance
// logic reads, and the busy-gate state type.
// Assumes a 32-bit status register with the layout given below.
package eia_pkg;
    localparam int STAT_W     = 32;
    localparam int ST_PIE     = 0;   // interrupt enable
    localparam int ST_IL_LO   = 4;   // current level, 6 bits
    localparam int ST_CRS_LO  = 10;  // current register set, 6 bits
    localparam int ST_NMI     = 22;  // nonmaskable handler active
    localparam int ST_RSIE    = 23;  // same-set re-entry enable
    localparam int ST_FIELD_W = 6;

    typedef enum logic {
        G_IDLE = 1'b0,
        G_BUSY = 1'b1
    } gate_e;
endpackage

// File: rtl/eia_decide.sv
// eia_decide: combinational acceptance rule for one external request.
// The nonmaskable flag overrides every maskable test. For a maskable request,
// the enable, the strict level compare and the register-set / re-entry test
// are applied in turn. Assumes the status fields arrive already sliced.
module eia_decide #(
    parameter int LVL_W = 6,
    parameter int RS_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_nmi,
    input  logic [LVL_W-1:0] req_level,
    input  logic [RS_W-1:0]  req_rset,
    input  logic             st_pie,
    input  logic [LVL_W-1:0] st_il,
    input  logic [RS_W-1:0]  st_crs,
    input  logic             st_nmi,
    input  logic             st_rsie,
    output logic             grant_ok
);
    // Priority chain: nonmaskable, enable, level, register set.
    always_comb begin
        if (req_nmi)                    grant_ok = !st_nmi;
        else if (!st_pie)               grant_ok = 1'b0;
        else if (req_level <= st_il)    grant_ok = 1'b0;
        else if (req_rset != st_crs)    grant_ok = 1'b1;
        else                            grant_ok = st_rsie;
    end

    p_nmi_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_nmi |-> (grant_ok == !st_nmi));
    p_pie_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_nmi && !st_pie) |-> !grant_ok);
    p_level_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_nmi && (req_level <= st_il)) |-> !grant_ok);
    p_same_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_nmi && (req_rset == st_crs) && !st_rsie) |-> !grant_ok);
    p_other_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_nmi && st_pie && (req_level > st_il) && (req_rset != st_crs)) |-> grant_ok);
endmodule

// File: rtl/eia_gate.sv
// eia_gate: turns a granted, valid request into a one-cycle accept pulse
// and blocks further accepts until the entry unit reports done.
// Assumes svc_done is meaningful only while busy; when idle it is ignored.
module eia_gate
    import eia_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic grant_ok,
    input  logic svc_done,
    output logic take,
    output logic acc_pulse,
    output logic busy
);
    gate_e state_q;

    // Accept only a valid, granted request while idle.
    always_comb take = req_valid && grant_ok && (state_q == G_IDLE);

    // Busy tracking: set on accept, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    state_q <= G_IDLE;
        else if (take)                                 state_q <= G_BUSY;
        else if (svc_done && state_q == G_BUSY)        state_q <= G_IDLE;
    end

    // Registered accept strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_pulse <= 1'b0;
        else        acc_pulse <= take;
    end

    always_comb busy = (state_q == G_BUSY);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |=> !acc_pulse);
    p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !acc_pulse);
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !svc_done) |=> busy);
    p_pulse_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> busy);
endmodule

// File: rtl/eia_capture.sv
// eia_capture: holds the accepted request fields for the entry unit.
// Loads on the accept decision and otherwise keeps its contents.
module eia_capture #(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = 6,
    parameter int RS_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_handler,
    input  logic [LVL_W-1:0]  in_level,
    input  logic [RS_W-1:0]   in_rset,
    input  logic              in_nmi,
    output logic [ADDR_W-1:0] out_handler,
    output logic [LVL_W-1:0]  out_level,
    output logic [RS_W-1:0]   out_rset,
    output logic              out_nmi
);
    // Request latch, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_handler <= '0;
            out_level   <= '0;
            out_rset    <= '0;
            out_nmi     <= 1'b0;
        end else if (load) begin
            out_handler <= in_handler;
            out_level   <= in_level;
            out_rset    <= in_rset;
            out_nmi     <= in_nmi;
        end
    end

    p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(out_handler) && $stable(out_level) &&
                   $stable(out_rset) && $stable(out_nmi)));
    p_load_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_handler == $past(in_handler) && out_level == $past(in_level)));
endmodule

// File: rtl/ext_irq_accept.sv
// ext_irq_accept: decides whether the core takes a request from the external
// interrupt controller, pulses accept for one cycle and latches the request.
// Assumes cur_status is the live status register, stable within a cycle.
module ext_irq_accept
    import eia_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = ST_FIELD_W,
    parameter int RS_W   = ST_FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [RS_W-1:0]   req_rset,
    input  logic              req_nmi,
    input  logic [ADDR_W-1:0] req_handler,
    input  logic [STAT_W-1:0] cur_status,
    input  logic              svc_done,
    output logic              acc_pulse,
    output logic [ADDR_W-1:0] acc_handler,
    output logic [LVL_W-1:0]  acc_level,
    output logic [RS_W-1:0]   acc_rset,
    output logic              acc_nmi
);
    localparam int IL_HI  = ST_IL_LO + LVL_W - 1;
    localparam int CRS_HI = ST_CRS_LO + RS_W - 1;

    logic grant_ok;
    logic take;
    logic busy;
    logic unused_status_bits;

    // Status bits that play no part in acceptance.
    assign unused_status_bits = ^{cur_status[ST_IL_LO-1:ST_PIE+1],
                                  cur_status[ST_NMI-1:CRS_HI+1],
                                  cur_status[STAT_W-1:ST_RSIE+1], busy};

    eia_decide #(.LVL_W(LVL_W), .RS_W(RS_W)) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_nmi   (req_nmi),
        .req_level (req_level),
        .req_rset  (req_rset),
        .st_pie    (cur_status[ST_PIE]),
        .st_il     (cur_status[IL_HI:ST_IL_LO]),
        .st_crs    (cur_status[CRS_HI:ST_CRS_LO]),
        .st_nmi    (cur_status[ST_NMI]),
        .st_rsie   (cur_status[ST_RSIE]),
        .grant_ok  (grant_ok)
    );

    eia_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .grant_ok  (grant_ok),
        .svc_done  (svc_done),
        .take      (take),
        .acc_pulse (acc_pulse),
        .busy      (busy)
    );

    eia_capture #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .RS_W(RS_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (take),
        .in_handler  (req_handler),
        .in_level    (req_level),
        .in_rset     (req_rset),
        .in_nmi      (req_nmi),
        .out_handler (acc_handler),
        .out_level   (acc_level),
        .out_rset    (acc_rset),
        .out_nmi     (acc_nmi)
    );

    p_idle_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !acc_pulse);
endmodule

// File: tb/ext_irq_accept_tb_top.sv
`timescale 1ns/1ps
module ext_irq_accept_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [5:0]  req_level;
    logic [5:0]  req_rset;
    logic        req_nmi;
    logic [31:0] req_handler;
    logic [31:0] cur_status;
    logic        svc_done;
    logic        acc_pulse;
    logic [31:0] acc_handler;
    logic [5:0]  acc_level;
    logic [5:0]  acc_rset;
    logic        acc_nmi;

    int tests  = 0;
    int failed = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ext_irq_accept dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .req_rset(req_rset), .req_nmi(req_nmi), .req_handler(req_handler),
        .cur_status(cur_status), .svc_done(svc_done), .acc_pulse(acc_pulse),
        .acc_handler(acc_handler), .acc_level(acc_level), .acc_rset(acc_rset),
        .acc_nmi(acc_nmi)
    );

    // Vector fields: enable, level, set, nmi-active, re-entry, req level, req set, req nmi, expected.
    typedef struct packed {
        logic       pie;
        logic [5:0] il;
        logic [5:0] crs;
        logic       nst;
        logic       rsie;
        logic [5:0] lvl;
        logic [5:0] rs;
        logic       nmi;
        logic       exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd63, 6'd5, 1'b0, 1'b0, 6'd0,  6'd5, 1'b1, 1'b1},  // R2 override
        '{1'b1, 6'd0,  6'd1, 1'b1, 1'b1, 6'd63, 6'd2, 1'b1, 1'b0},  // R2 nmi active
        '{1'b0, 6'd1,  6'd1, 1'b0, 1'b1, 6'd5,  6'd2, 1'b0, 1'b0},  // R3
        '{1'b1, 6'd1,  6'd1, 1'b0, 1'b0, 6'd5,  6'd2, 1'b0, 1'b1},  // R5
        '{1'b1, 6'd3,  6'd1, 1'b0, 1'b1, 6'd3,  6'd2, 1'b0, 1'b0},  // R4 equal
        '{1'b1, 6'd3,  6'd1, 1'b0, 1'b1, 6'd2,  6'd2, 1'b0, 1'b0},  // R4 below
        '{1'b1, 6'd3,  6'd1, 1'b0, 1'b0, 6'd4,  6'd2, 1'b0, 1'b1},  // R4 one above
        '{1'b1, 6'd3,  6'd7, 1'b0, 1'b0, 6'd9,  6'd7, 1'b0, 1'b0},  // R6 no re-entry
        '{1'b1, 6'd3,  6'd7, 1'b0, 1'b1, 6'd9,  6'd7, 1'b0, 1'b1},  // R6 re-entry
        '{1'b1, 6'd62, 6'd63,1'b0, 1'b0, 6'd63, 6'd0, 1'b0, 1'b1},  // R5 extremes
        '{1'b0, 6'd63, 6'd4, 1'b0, 1'b0, 6'd0,  6'd4, 1'b1, 1'b1}   // R2 same set
    };
    localparam int VTAG [NV] = '{2, 2, 3, 5, 4, 4, 4, 6, 6, 5, 2};

    function automatic logic [31:0] mk_status(logic pie, logic [5:0] il, logic [5:0] crs,
                                              logic nst, logic rsie);
        logic [31:0] s;
        s = 32'h0000_0002;          // unrelated bit set
        s[0] = pie;
        s[9:4] = il;
        s[15:10] = crs;
        s[21:16] = 6'h2A;           // unrelated field
        s[22] = nst;
        s[23] = rsie;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] l, input logic [5:0] r,
                         input logic n, input logic [31:0] h);
        req_valid = v; req_level = l; req_rset = r; req_nmi = n; req_handler = h;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failed++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; svc_done = 1'b0;
        cur_status = mk_status(1'b1, 6'd0, 6'd1, 1'b0, 1'b1);
        drive(1'b1, 6'd9, 6'd2, 1'b0, 32'hDEAD_0000);
        repeat (3) @(negedge clk);
        chk("R1 pulse in reset", {31'd0, acc_pulse}, 32'd0);
        chk("R1 handler in reset", acc_handler, 32'd0);
        drive(1'b0, 6'd0, 6'd0, 1'b0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse after reset", {31'd0, acc_pulse}, 32'd0);
        chk("R1 fields after reset", {acc_nmi, acc_rset, acc_level}, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            cur_status = mk_status(VEC[i].pie, VEC[i].il, VEC[i].crs, VEC[i].nst, VEC[i].rsie);
            drive(1'b1, VEC[i].lvl, VEC[i].rs, VEC[i].nmi, 32'h1000_0000 + 32'(i * 16));
            @(negedge clk);
            chk($sformatf("R%0d vec %0d accept", VTAG[i], i), {31'd0, acc_pulse}, {31'd0, VEC[i].exp});
            if (VEC[i].exp) begin
                chk($sformatf("R7 vec %0d handler", i), acc_handler, 32'h1000_0000 + 32'(i * 16));
                chk($sformatf("R7 vec %0d level/set/nmi", i),
                    {19'd0, acc_nmi, acc_rset, acc_level}, {19'd0, VEC[i].nmi, VEC[i].rs, VEC[i].lvl});
            end
            drive(1'b0, 6'd0, 6'd0, 1'b0, 32'd0);
            svc_done = 1'b1;
            @(negedge clk);
            svc_done = 1'b0;
        end

        // R9: acceptable fields with valid low
        cur_status = mk_status(1'b1, 6'd0, 6'd1, 1'b0, 1'b1);
        drive(1'b0, 6'd40, 6'd3, 1'b1, 32'hBBBB_0000);
        @(negedge clk);
        chk("R9 no accept with valid low", {31'd0, acc_pulse}, 32'd0);
        @(negedge clk);
        chk("R9 fields untouched", acc_handler, 32'h1000_00A0);

        // R7/R8: accept A, hold B during busy, release with done
        drive(1'b1, 6'd10, 6'd2, 1'b0, 32'hAAAA_0000);
        @(negedge clk);
        chk("R7 accept A pulse", {31'd0, acc_pulse}, 32'd1);
        chk("R7 accept A handler", acc_handler, 32'hAAAA_0000);
        drive(1'b1, 6'd20, 6'd3, 1'b1, 32'hBBBB_0000);
        @(negedge clk);
        chk("R7 pulse one cycle wide", {31'd0, acc_pulse}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R8 no accept while busy", {31'd0, acc_pulse}, 32'd0);
        chk("R8 fields held while busy", acc_handler, 32'hAAAA_0000);
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
        chk("R8 no accept on done edge", {31'd0, acc_pulse}, 32'd0);
        chk("R8 fields held on done edge", {26'd0, acc_level}, 32'd10);
        @(negedge clk);
        chk("R8 accept B after done", {31'd0, acc_pulse}, 32'd1);
        chk("R8 B fields", {19'd0, acc_nmi, acc_rset, acc_level}, {19'd0, 1'b1, 6'd3, 6'd20});
        drive(1'b0, 6'd0, 6'd0, 1'b0, 32'd0);
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule